// File: doc/BRIEF.md
# Infrared SIR Pulse Encoder

This block turns the serial transmit line of a host UART into the return-to-zero pulse train used by slow infrared links. Every bit on the wire occupies sixteen slots. The bit's value is captured once, as a new period begins. A zero bit then produces a short high pulse three slots wide, beginning at slot 7. A one bit leaves the infrared line low for the whole period. The UART's idle level is high, so an idle UART therefore keeps the emitter dark.

The block runs on a single free-running reference clock. A one-cycle strobe, `slot_en`, marks each tick of the sixteen-times-baud timebase, which comes from a generator outside this block. A pulse-width limiter counts reference cycles and cuts the infrared high time at `MAX_HIGH_CYC` cycles. This protects the emitter from a pulse that is too long, for example when the slot strobe is slow. A synchronous active-high reset holds the output low at once and restarts the slot sequence.

Top module: `irenc_sir_tx`

## Requirements
- R1: While `rst` is high, `ir_out` is low in the same cycle, whatever `tx` and `slot_en` do.
- R2: A bit captured as 1 keeps `ir_out` low for all sixteen slots of its period.
- R3: A bit captured as 0 drives `ir_out` high starting in slot 7. Slot 0 is the slot opened by the strobe that captures the bit. The rise is seen one reference cycle after the strobe that opens slot 7.
- R4: When the limit is not reached, a 0 bit holds `ir_out` high for exactly three slots, which is 3×P reference cycles when the strobe period is P ≥ 2 cycles.
- R5: `ir_out` never stays high for more than `MAX_HIGH_CYC` consecutive reference cycles. A longer pulse is cut to exactly that length, and its start is not moved.
- R6: `tx` is sampled only on the strobe that opens slot 0. Changes to `tx` later in the period have no effect on that period's output.
- R7: The first strobe after reset is released opens slot 0 of a new bit period. `ir_out` stays low until a 0 bit has been captured.
- R8: Back-to-back bit periods are encoded independently, so each 0 bit in a sequence gives one pulse of its own.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running reference clock |
| rst | input | 1 | Synchronous active-high reset; also gates `ir_out` low directly |
| slot_en | input | 1 | One-cycle strobe per sixteen-times-baud tick |
| tx | input | 1 | UART transmit line, already synchronous to `clk` |
| ir_out | output | 1 | Encoded infrared drive, high means emitter on |

## Verification
The assertions assume that `tx`, `slot_en` and `rst` are already synchronous to `clk`, and that strobes are not merged or dropped by the timebase. The rise-position and quiet-bit properties also rely on the bit register changing only on slot-0 strobes, which the latch's own stability property confirms. The stimulus changes inputs only one time unit after a rising edge. It always issues whole groups of sixteen strobes per bit, spaced at least two cycles apart, so every measured pulse lands inside one period.

// File: rtl/irenc_pkg.sv
package irenc_pkg;

    localparam int unsigned SLOTS_PER_BIT = 16;
    localparam int unsigned SLOT_W        = $clog2(SLOTS_PER_BIT);
    localparam int unsigned PULSE_AT      = 7;
    localparam int unsigned PULSE_SLOTS   = 3;

    typedef logic [SLOT_W-1:0] slot_t;

    localparam slot_t LAST_SLOT   = slot_t'(SLOTS_PER_BIT - 1);
    localparam slot_t PULSE_BEGIN = slot_t'(PULSE_AT);
    localparam slot_t PULSE_END   = slot_t'(PULSE_AT + PULSE_SLOTS);

    // Encoder datapath state seen by the pulse shaper.
    typedef struct packed {
        slot_t slot;
        logic  data;
        logic  req;
    } enc_state_t;

    function automatic logic in_pulse_window(slot_t s);
        return (s >= PULSE_BEGIN) && (s < PULSE_END);
    endfunction

endpackage

// File: rtl/irenc_slot_ctr.sv
module irenc_slot_ctr
    import irenc_pkg::*;
(
    input  logic  clk,
    input  logic  rst,
    input  logic  slot_en,
    output slot_t slot,
    output logic  wrap
);

    slot_t slot_q;

    // Reset parks the counter on the last slot so the next strobe opens slot 0.
    always_ff @(posedge clk) begin
        if (rst) begin
            slot_q <= LAST_SLOT;
        end else if (slot_en) begin
            slot_q <= slot_t'(slot_q + 1'b1);
        end
    end

    assign slot = slot_q;
    assign wrap = slot_en && (slot_q == LAST_SLOT);

    // R7: the slot position only moves on a strobe.
    a_r7_slot_hold: assert property (@(posedge clk) disable iff (rst)
        !slot_en |=> $stable(slot_q));

endmodule

// File: rtl/irenc_bit_latch.sv
module irenc_bit_latch (
    input  logic clk,
    input  logic rst,
    input  logic wrap,
    input  logic tx,
    output logic data
);

    logic data_q;

    // Idle value is 1, which encodes to a dark emitter.
    always_ff @(posedge clk) begin
        if (rst) begin
            data_q <= 1'b1;
        end else if (wrap) begin
            data_q <= tx;
        end
    end

    assign data = data_q;

    // R6: the captured bit is held for the whole period.
    a_r6_bit_held: assert property (@(posedge clk) disable iff (rst)
        !wrap |=> $stable(data_q));

endmodule

// File: rtl/irenc_limiter.sv
module irenc_limiter #(
    parameter int unsigned MAX_HIGH_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic req,
    output logic ir
);

    localparam int unsigned CNT_W = $clog2(MAX_HIGH_CYC + 1);
    localparam logic [CNT_W-1:0] CAP = CNT_W'(MAX_HIGH_CYC);

    logic [CNT_W-1:0] hi_cnt;
    logic             ir_q;

    always_ff @(posedge clk) begin
        if (rst || !req) begin
            hi_cnt <= '0;
            ir_q   <= 1'b0;
        end else if (hi_cnt < CAP) begin
            hi_cnt <= hi_cnt + 1'b1;
            ir_q   <= 1'b1;
        end else begin
            ir_q   <= 1'b0;
        end
    end

    assign ir = ir_q;

    // Independent run-length observer for the cap check.
    logic [CNT_W:0] chk_run;
    always_ff @(posedge clk) begin
        if (rst || !ir_q) begin
            chk_run <= '0;
        end else if (chk_run <= {1'b0, CAP}) begin
            chk_run <= chk_run + 1'b1;
        end
    end

    // R5: the high run never passes the ceiling.
    a_r5_high_cap: assert property (@(posedge clk) disable iff (rst)
        ir_q |-> (chk_run < {1'b0, CAP}));

endmodule

// File: rtl/irenc_sir_tx.sv
module irenc_sir_tx
    import irenc_pkg::*;
#(
    parameter int unsigned MAX_HIGH_CYC = 200
) (
    input  logic clk,
    input  logic rst,
    input  logic slot_en,
    input  logic tx,
    output logic ir_out
);

    slot_t      slot;
    logic       wrap;
    logic       data;
    logic       ir_q;
    enc_state_t st;

    irenc_slot_ctr u_slot (
        .clk     (clk),
        .rst     (rst),
        .slot_en (slot_en),
        .slot    (slot),
        .wrap    (wrap)
    );

    irenc_bit_latch u_bit (
        .clk  (clk),
        .rst  (rst),
        .wrap (wrap),
        .tx   (tx),
        .data (data)
    );

    always_comb begin
        st.slot = slot;
        st.data = data;
        st.req  = !data && in_pulse_window(slot);
    end

    irenc_limiter #(
        .MAX_HIGH_CYC (MAX_HIGH_CYC)
    ) u_lim (
        .clk (clk),
        .rst (rst),
        .req (st.req),
        .ir  (ir_q)
    );

    assign ir_out = ir_q & ~rst;

    // R1: reset keeps the emitter dark.
    a_r1_reset_dark: assert property (@(posedge clk)
        rst |-> !ir_out);

    // R2: a bit held at 1 for two samples leaves the output low.
    a_r2_one_quiet: assert property (@(posedge clk) disable iff (rst)
        (st.data && $past(st.data)) |-> !ir_out);

    // R3: a pulse only starts while a zero bit is held.
    a_r3_rise_on_zero: assert property (@(posedge clk) disable iff (rst)
        $rose(ir_out) |-> !st.data);

endmodule

// File: tb/irenc_sir_tx_bench.sv
module irenc_sir_tx_bench;

    localparam int unsigned CAP = 10;

    logic clk = 1'b0;
    logic rst, slot_en, tx;
    logic ir_out;

    int checks = 0;
    int errors = 0;

    always #2 clk = ~clk;

    irenc_sir_tx #(.MAX_HIGH_CYC(CAP)) u_irenc_sir_tx (
        .clk     (clk),
        .rst     (rst),
        .slot_en (slot_en),
        .tx      (tx),
        .ir_out  (ir_out)
    );

    task automatic chk(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // One bit period of sixteen strobes, P cycles apart. Reports high
    // cycle count and the slot in which the output was first seen high.
    task automatic send_bit(input logic b, input int p, input int flip_at,
                            output int high, output int first);
        high  = 0;
        first = -1;
        tx    = b;
        for (int s = 0; s < 16; s++) begin
            if (s == flip_at) tx = ~b;
            for (int c = 0; c < p; c++) begin
                slot_en = (c == 0);
                @(posedge clk);
                #1;
                if (ir_out) begin
                    high++;
                    if (first < 0) first = s;
                end
            end
        end
        slot_en = 1'b0;
    endtask

    task automatic t_one_bits();
        int h, f;
        for (int i = 0; i < 2; i++) begin
            send_bit(1'b1, 2, -1, h, f);
            chk("R2 one bit high cycles", h, 0);
        end
    endtask

    task automatic t_zero_width(input int p, input int exp_high, input string req);
        int h, f;
        send_bit(1'b0, p, -1, h, f);
        chk("R3 pulse start slot", f, 7);
        chk(req, h, exp_high);
    endtask

    task automatic t_pattern();
        logic pat [5] = '{1'b0, 1'b1, 1'b0, 1'b0, 1'b1};
        int h, f;
        foreach (pat[i]) begin
            send_bit(pat[i], 2, -1, h, f);
            chk("R8 per-bit high cycles", h, pat[i] ? 0 : 6);
            chk("R8 per-bit start slot", f, pat[i] ? -1 : 7);
        end
    endtask

    task automatic t_mid_change();
        int h, f;
        send_bit(1'b0, 2, 3, h, f);
        chk("R6 zero kept after tx rises", h, 6);
        send_bit(1'b1, 2, 3, h, f);
        chk("R6 one kept after tx falls", h, 0);
    endtask

    task automatic t_reset_mid_pulse();
        int h, f;
        tx = 1'b0;
        for (int s = 0; s < 8; s++) begin
            for (int c = 0; c < 2; c++) begin
                slot_en = (c == 0);
                @(posedge clk);
                #1;
            end
        end
        slot_en = 1'b0;
        chk("R3 pulse present before reset", int'(ir_out), 1);
        rst = 1'b1;
        #1;
        chk("R1 output low at once in reset", int'(ir_out), 0);
        h = 0;
        for (int c = 0; c < 6; c++) begin
            slot_en = c[0];
            @(posedge clk);
            #1;
            if (ir_out) h++;
        end
        chk("R1 output low through reset", h, 0);
        slot_en = 1'b0;
        rst = 1'b0;
        send_bit(1'b1, 2, -1, h, f);
        chk("R7 dark until zero captured", h, 0);
        send_bit(1'b0, 2, -1, h, f);
        chk("R7 first pulse slot after reset", f, 7);
        chk("R7 first pulse width after reset", h, 6);
    endtask

    initial begin
        #400000;
        errors++;
        checks++;
        $display("FAIL watchdog: actual=timeout expected=completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        rst = 1'b1;
        slot_en = 1'b0;
        tx = 1'b1;
        repeat (3) @(posedge clk);
        #1;
        chk("R1 reset state", int'(ir_out), 0);
        rst = 1'b0;
        t_one_bits();
        t_zero_width(2, 6, "R4 width P=2");
        t_zero_width(3, 9, "R4 width P=3");
        t_zero_width(4, CAP, "R5 capped width P=4");
        t_zero_width(6, CAP, "R5 capped width P=6");
        t_pattern();
        t_mid_change();
        t_reset_mid_pulse();
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule